// File: doc/BRIEF.md
# Zero-Crossing Timeout Watchdog

This block watches six signal channels (three voltage phases and three current phases) for missing zero crossings. Each channel owns a 16-bit down-counter that is reloaded with a shared, programmable timeout value every time the upstream detector pulses that channel's crossing input. The counters step down once per tick of a 16 kHz time base, which the block derives from the system clock with an internal prescaler. A counter that runs out before a crossing arrives marks its channel as stalled, as happens when the signal sits at a fixed DC level.

Stall flags are sticky and cleared by writing ones. A per-channel mask routes them onto one active-low interrupt. Software reaches the block through a simple write port that has three targets: the timeout value, the interrupt mask and the flag-clear strobe. The flag and mask fields take status bit positions 3 to 8, so they sit at the same place as their bits in a wider status word.

Top module: `zxw_top`

## Requirements
- R1: After reset all flags are 0, the mask is 0, irq_no is 1 and the timeout value is 0xFFFF. With that value, no flag sets within a few hundred ticks.
- R2: While tick_en_i is 1, one tick fires every TICK_DIV clock cycles, and the first tick fires on the TICK_DIV-th rising edge after tick_en_i rises. While tick_en_i is 0, no tick fires, the prescaler is held cleared and all counters hold their values.
- R3: Each tick decrements every non-zero counter by one. A counter loaded with T sets its channel flag on the T-th tick that follows, provided no crossing arrives in between.
- R4: A one-cycle pulse on zx_i[k] reloads counter k with the timeout value. If crossings arrive more often than every T ticks, flag k stays 0.
- R5: A set flag stays set until it is cleared. After a timeout the counter stays at zero, so clearing the flag does not cause it to set again until a crossing reloads that counter.
- R6: A write to address 2 clears each flag k whose data bit k+3 is 1. Flags whose data bit is 0 are left unchanged.
- R7: A write to address 1 loads the mask from data bits [8:3], where bit k+3 enables channel k. irq_no is 0 exactly when some flag k is set and its mask bit is also set.
- R8: A write to address 0 loads the timeout from data bits [15:0] and reloads all six counters with the new value in the same cycle.
- R9: A timeout value of 0 disables timeouts, so no flag sets however many ticks pass.
- R10: Channels 0, 1 and 2 are voltage phases A, B and C, mapped to status bits 3, 4 and 5. Channels 3, 4 and 5 are current phases A, B and C, mapped to status bits 6, 7 and 8. flags_o[k] reports channel k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_en_i | input | 1 | Enables the 16 kHz time base |
| zx_i | input | 6 | Zero-crossing pulses, one per channel |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write target: 0 timeout, 1 mask, 2 flag clear |
| wr_data_i | input | 16 | Write data |
| flags_o | output | 6 | Sticky timeout flags, bit k = channel k |
| irq_no | output | 1 | Masked interrupt, active low |

## Verification
The hardest situation to reach is the cycle in which a reload and the decisive tick meet. Examples are a timeout rewrite that lands just one tick before the old count would expire, or an expired channel that must stay silent after its flag is cleared. The bench makes this deterministic. It holds tick_en_i low, because that keeps the prescaler cleared, and only then writes the timeout. It then raises tick_en_i at a known edge, so every later tick falls on an edge that the bench can count. With the tick phase fixed this way, writes and crossing pulses can be placed one cycle before or after expiry, and flags can be sampled on the exact edge where they must change.

// File: rtl/zxw_pkg.sv
package zxw_pkg;
  localparam int unsigned NUM_CH   = 6;
  localparam int unsigned TMO_W    = 16;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned FLAG_LSB = 3;  // flag field sits at status bits [8:3]
  localparam logic [TMO_W-1:0] TMO_RST = 16'hFFFF;

  typedef enum logic [1:0] {
    ADDR_TMO  = 2'd0,
    ADDR_MASK = 2'd1,
    ADDR_CLR  = 2'd2,
    ADDR_RSVD = 2'd3
  } zxw_addr_e;
endpackage

// File: rtl/zxw_prescaler.sv
module zxw_prescaler #(
  parameter int unsigned DIV = 15625
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  generate
    if (DIV <= 1) begin : g_bypass
      assign tick_o = en_i;
    end else begin : g_div
      logic [CW-1:0] cnt_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)          cnt_q <= '0;
        else if (!en_i)       cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
      end

      assign tick_o = en_i && (cnt_q == LAST);

      // R2: ticks are never back to back when dividing
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/zxw_regs.sv
module zxw_regs
  import zxw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [TMO_W-1:0]  tmo_o,
  output logic              tmo_wr_o,
  output logic [TMO_W-1:0]  tmo_new_o,
  output logic [NUM_CH-1:0] mask_o,
  output logic [NUM_CH-1:0] clr_o
);
  logic sel_tmo, sel_mask, sel_clr;

  assign sel_tmo  = wr_en_i && (wr_addr_i == ADDR_TMO);
  assign sel_mask = wr_en_i && (wr_addr_i == ADDR_MASK);
  assign sel_clr  = wr_en_i && (wr_addr_i == ADDR_CLR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmo_o  <= TMO_RST;
      mask_o <= '0;
    end else begin
      if (sel_tmo)  tmo_o  <= wr_data_i[TMO_W-1:0];
      if (sel_mask) mask_o <= wr_data_i[FLAG_LSB +: NUM_CH];
    end
  end

  assign tmo_wr_o  = sel_tmo;
  assign tmo_new_o = wr_data_i[TMO_W-1:0];
  assign clr_o     = sel_clr ? wr_data_i[FLAG_LSB +: NUM_CH] : '0;

  // R8: timeout register takes the written value on the next cycle
  tmo_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_wr_o |=> (tmo_o == $past(tmo_new_o)));
endmodule

// File: rtl/zxw_chan_timer.sv
module zxw_chan_timer
  import zxw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             zx_i,
  input  logic             tmo_wr_i,
  input  logic [TMO_W-1:0] tmo_new_i,
  input  logic [TMO_W-1:0] tmo_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [TMO_W-1:0] cnt_q;
  logic [TMO_W-1:0] load_val;
  logic             load;
  logic             expire;

  assign load     = zx_i || tmo_wr_i;
  assign load_val = tmo_wr_i ? tmo_new_i : tmo_i;
  // reload beats an expiring tick in the same cycle
  assign expire   = tick_i && !load && (cnt_q == TMO_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= TMO_RST;
    else if (load)                  cnt_q <= load_val;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (expire) flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R5: an expired counter holds zero until reloaded
  stuck_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0 && !load) |=> (cnt_q == '0));

  // R5: flag is sticky without a clear
  flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);

  // R9: zero timeout never raises a flag
  zero_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_i == '0 && !tmo_wr_i && !flag_o) |=> !flag_o);

  // R3: a flag only rises on a tick
  flag_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(tick_i));
endmodule

// File: rtl/zxw_top.sv
module zxw_top
  import zxw_pkg::*;
#(
  parameter int unsigned TICK_DIV = 15625
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_en_i,
  input  logic [NUM_CH-1:0] zx_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [NUM_CH-1:0] flags_o,
  output logic              irq_no
);
  logic              tick;
  logic [TMO_W-1:0]  tmo;
  logic              tmo_wr;
  logic [TMO_W-1:0]  tmo_new;
  logic [NUM_CH-1:0] mask;
  logic [NUM_CH-1:0] clr;

  zxw_prescaler #(.DIV(TICK_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (tick_en_i),
    .tick_o (tick)
  );

  zxw_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .tmo_o     (tmo),
    .tmo_wr_o  (tmo_wr),
    .tmo_new_o (tmo_new),
    .mask_o    (mask),
    .clr_o     (clr)
  );

  generate
    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      zxw_chan_timer u_tmr (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .tick_i    (tick),
        .zx_i      (zx_i[k]),
        .tmo_wr_i  (tmo_wr),
        .tmo_new_i (tmo_new),
        .tmo_i     (tmo),
        .clr_i     (clr[k]),
        .flag_o    (flags_o[k])
      );
    end
  endgenerate

  assign irq_no = ~|(flags_o & mask);
endmodule

// File: tb/zxw_top_tb.sv
module zxw_top_tb;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [5:0]  zx = '0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  flags;
  logic        irq_n;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  zxw_top #(.TICK_DIV(D)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .tick_en_i (tick_en),
    .zx_i      (zx),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .flags_o   (flags),
    .irq_no    (irq_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // stop ticks, load timeout, clear all flags
  task automatic prep(input logic [15:0] t);
    tick_en = 1'b0;
    wr(2'd0, t);
    wr(2'd2, 16'h01F8);
  endtask

  task automatic t_reset;
    chk("R1 flags", flags, 6'h00);
    chk("R1 irq", irq_n, 1'b1);
    tick_en = 1'b1;
    edges(300 * D);
    chk("R1 default timeout long", flags, 6'h00);
    wr(2'd1, 16'h0000);
    chk("R1 mask default keeps irq high", irq_n, 1'b1);
  endtask

  task automatic t_tick;
    prep(16'd1);
    tick_en = 1'b1;
    edges(D - 1);
    chk("R2 no tick before divide", flags, 6'h00);
    edges(1);
    chk("R2 first tick at TICK_DIV", flags, 6'h3F);
    prep(16'd2);
    tick_en = 1'b1;
    edges(D);
    tick_en = 1'b0;
    edges(10 * D);
    chk("R2 counters frozen while disabled", flags, 6'h00);
    tick_en = 1'b1;
    edges(D);
    chk("R2 resumes after enable", flags, 6'h3F);
  endtask

  task automatic t_timeout;
    prep(16'd3);
    tick_en = 1'b1;
    edges(3 * D - 1);
    chk("R3 not expired before T ticks", flags, 6'h00);
    edges(1);
    chk("R3 expired on T-th tick", flags, 6'h3F);
  endtask

  task automatic t_reload;
    prep(16'd3);
    tick_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      edges(2 * D - 1);
      zx = 6'b010010;
      edges(1);
      zx = '0;
    end
    chk("R4 crossings keep ch1 and ch4 clear", flags, 6'b101101);
    chk("R10 current B channel is flags_o[4]", flags[4], 1'b0);
    wr(2'd2, 16'h0008);
    chk("R6 W1C clears only status bit 3", flags, 6'b101100);
    wr(2'd2, 16'h0000);
    chk("R6 zero bits leave flags", flags, 6'b101100);
    wr(2'd2, 16'h0100);
    chk("R10 status bit 8 is current C", flags, 6'b001100);
  endtask

  task automatic t_sticky;
    prep(16'd2);
    tick_en = 1'b1;
    edges(2 * D);
    chk("R5 all expired", flags, 6'h3F);
    edges(20 * D);
    chk("R5 flags sticky", flags, 6'h3F);
    wr(2'd2, 16'h01F8);
    edges(20 * D);
    chk("R5 no re-fire at zero", flags, 6'h00);
    zx = 6'b000100;
    edges(1);
    zx = '0;
    edges(3 * D);
    chk("R5 re-armed channel fires again", flags, 6'b000100);
  endtask

  task automatic t_mask;
    prep(16'd1);
    wr(2'd1, 16'h0020);
    tick_en = 1'b1;
    edges(D);
    chk("R7 masked flag drives irq low", irq_n, 1'b0);
    wr(2'd2, 16'h0020);
    chk("R7 irq high after clear", irq_n, 1'b1);
    chk("R7 other flags unmasked", flags, 6'b111011);
    wr(2'd1, 16'h0008);
    chk("R7 mask on set flag ch0", irq_n, 1'b0);
    wr(2'd1, 16'h0000);
    chk("R7 mask off", irq_n, 1'b1);
  endtask

  task automatic t_wrreload;
    prep(16'd3);
    tick_en = 1'b1;
    edges(2 * D);
    wr(2'd0, 16'd3);
    edges(D - 1);
    chk("R8 old expiry suppressed", flags, 6'h00);
    edges(2 * D - 1);
    chk("R8 before new expiry", flags, 6'h00);
    edges(1);
    chk("R8 new value expires", flags, 6'h3F);
  endtask

  task automatic t_zero;
    prep(16'd0);
    tick_en = 1'b1;
    edges(40 * D);
    chk("R9 zero timeout disables", flags, 6'h00);
    zx = 6'h3F;
    edges(1);
    zx = '0;
    edges(40 * D);
    chk("R9 crossings with zero timeout", flags, 6'h00);
  endtask

  initial begin
    edges(3);
    rst_n = 1'b1;
    edges(1);
    t_reset();
    t_tick();
    t_timeout();
    t_reload();
    t_sticky();
    t_mask();
    t_wrreload();
    t_zero();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule